// File: doc/BRIEF.md
# Serial Channel with Two-Entry Receive Queue

This block is one asynchronous serial channel driven through a byte-wide register port. Software loads characters into a transmit holding register, and the block serialises them onto `txd`. Characters arriving on `rxd` are deserialised into a two-entry queue, and software reads them back oldest first. The frame format is set in a mode register: 7 or 8 data bits, no parity or even or odd parity, and one or two stop bits. The channel counts an oversampling tick that comes either from an internal divider or from an external clock-enable input.

Framing, parity and overrun errors are sticky and are cleared by writing 1 to them. Three level interrupt outputs report three conditions: the transmit holding register is empty, the receive queue has reached a chosen fill (one entry or two), and an error flag is set. An expansion register holds an infrared mode bit and a 3-bit divider code for an encoder outside this block. The block only stores these two fields.

Register offsets: 0 status, 1 transmit data, 2 receive data, 3 mode, 4 control, 5 expansion. A read of offset 2 with `reg_rd` high removes the oldest entry from the queue.

Top module: `sio_uart_channel`

## Requirements
- R1: After reset the status register reads 0x01 (only bit 0, transmit holding empty, set). The transmit data, receive data, mode, control and expansion registers read 0x00, and all three interrupt outputs are low.
- R2: A transmitted frame is a low start bit, then the data bits LSB first, then a high stop bit. Each bit lasts 16 oversampling ticks, and the line idles high.
- R3: Writing offset 1 clears status bit 0. Bit 0 returns to 1 when the byte moves into the idle shifter. Status bit 2 (busy) is 1 from that move until the last stop bit ends, so a second write made while the shifter is busy reads as status 0x04.
- R4: Mode register bits are: bit 4 (1 = 8 data bits, 0 = 7 bits, sending bits 6:0), bit 3 (parity enable), bit 2 (1 = odd, 0 = even) and bit 1 (1 = two stop bits). The parity bit follows the data, so that the count of ones over data and parity is even or odd as selected.
- R5: A received character is read at offset 2 and sets status bit 1 while the queue holds at least one entry. In 7-bit mode, bit 7 of the received data reads 0.
- R6: The queue holds two characters, and status bit 3 is set while both entries are filled. Reads return the oldest entry first. A read of an empty queue returns 0x00.
- R7: A character that completes while both entries are filled sets status bit 4 (overrun) and is discarded, and the buffered entries are kept. A read in the same cycle as the completion frees an entry, so the character is stored and no overrun is flagged.
- R8: A parity mismatch sets status bit 5. A first stop bit sampled low sets status bit 6. The character is still stored in both cases.
- R9: Status bits 6:4 are cleared only by writing 1 to the same bit at offset 0. Writing 0 to them leaves them set, and writes to bits 3:0 have no effect.
- R10: Only these bits are writable and read back: mode bits 4:0; control bits 6 (error interrupt enable), 5 (receive interrupt enable), 4 (transmit interrupt enable), 1 (receive threshold, 1 = two entries) and 0 (channel enable); expansion bits 6:4 (divider code) and 0 (infrared mode). Every other bit reads 0.
- R11: `irq_txe` = control bit 4 AND status bit 0. `irq_rxf` = control bit 5 AND (two entries filled when control bit 1 = 1, otherwise at least one entry). `irq_rxerr` = control bit 6 AND any of status bits 6:4.
- R12: Clearing control bit 0 returns the transmitter and the receiver to idle and empties the queue. The register contents are kept.
- R13: With mode bit 0 set, `ext_tick` is the oversampling tick, so no bit advances while it is low. With mode bit 0 clear, the internal divider gives one tick every BAUD_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; at offset 2 it removes the oldest entry from the queue |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| ext_tick | input | 1 | External oversampling clock enable |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_txe | output | 1 | Transmit holding register empty interrupt |
| irq_rxf | output | 1 | Receive queue threshold interrupt |
| irq_rxerr | output | 1 | Receive error interrupt |

## Verification
The case that needs care is a software read of the receive data register in the same clock as a third character completing while both queue entries are full. In that cycle the read frees an entry and the deserialiser pushes into the full queue. The bench fills the queue and then issues a single read at an offset that it sweeps, clock by clock, across the window in which the third character completes. In every trial the first read must return the oldest character. The overrun flag must be set exactly when the third character is missing from the queue afterwards, and the sweep must produce both outcomes.

// File: rtl/sio_uart_pkg.sv
package sio_uart_pkg;

   localparam int unsigned REG_AW = 3;
   localparam int unsigned BYTE_W = 8;

   localparam logic [REG_AW-1:0] A_STAT = 3'd0;
   localparam logic [REG_AW-1:0] A_TXD  = 3'd1;
   localparam logic [REG_AW-1:0] A_RXD  = 3'd2;
   localparam logic [REG_AW-1:0] A_MODE = 3'd3;
   localparam logic [REG_AW-1:0] A_CTRL = 3'd4;
   localparam logic [REG_AW-1:0] A_EXP  = 3'd5;

   typedef struct packed {
      logic char8;
      logic par_en;
      logic par_odd;
      logic stop2;
      logic ext_clk;
   } mode_t;

   typedef struct packed {
      logic err_ie;
      logic rxf_ie;
      logic txe_ie;
      logic rx_two;
      logic en;
   } ctrl_t;

   typedef enum logic [2:0] {
      TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
   } tx_state_e;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
   } rx_state_e;

   // index of the last data bit for the selected character length
   function automatic logic [2:0] last_bit(input logic char8);
      return char8 ? 3'd7 : 3'd6;
   endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
   import sio_uart_pkg::*;
#(
   parameter int unsigned OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   input  logic              char8,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   output logic              txd,
   output logic              busy
);
   localparam int unsigned CW = $clog2(OSR);

   tx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [2:0]        idx;
   logic [BYTE_W-1:0] sh;
   logic              par;
   logic              bit_end;

   assign bit_end = tick && (cnt == CW'(OSR - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= TX_IDLE;
         cnt <= '0;
         idx <= '0;
         sh  <= '0;
         par <= 1'b0;
      end else if (clr) begin
         st  <= TX_IDLE;
         cnt <= '0;
      end else if (st == TX_IDLE) begin
         if (load) begin
            st  <= TX_START;
            sh  <= din;
            par <= 1'b0;
            cnt <= '0;
            idx <= '0;
         end
      end else begin
         if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
         if (bit_end) begin
            unique case (st)
               TX_START: st <= TX_DATA;
               TX_DATA: begin
                  par <= par ^ sh[0];
                  sh  <= sh >> 1;
                  if (idx == last_bit(char8)) st <= par_en ? TX_PAR : TX_STOP1;
                  else                        idx <= idx + 1'b1;
               end
               TX_PAR:   st <= TX_STOP1;
               TX_STOP1: st <= stop2 ? TX_STOP2 : TX_IDLE;
               default:  st <= TX_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (st)
         TX_START: txd = 1'b0;
         TX_DATA:  txd = sh[0];
         TX_PAR:   txd = par ^ par_odd;
         default:  txd = 1'b1;
      endcase
   end

   assign busy = (st != TX_IDLE);

   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
      $rose(busy) |-> !txd); // R2

endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_uart_pkg::*;
#(
   parameter int unsigned OSR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              rxd,
   input  logic              char8,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [BYTE_W-1:0] data,
   output logic              perr,
   output logic              ferr
);
   localparam int unsigned CW   = $clog2(OSR);
   localparam int unsigned HALF = OSR / 2;

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [2:0]        idx;
   logic [BYTE_W-1:0] sh;
   logic              par;
   logic              perr_pend;
   logic              s1, rxs;
   logic              bit_end;

   assign bit_end = tick && (cnt == CW'(OSR - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1  <= 1'b1;
         rxs <= 1'b1;
      end else begin
         s1  <= rxd;
         rxs <= s1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0; par <= 1'b0;
         perr_pend <= 1'b0; done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
      end else if (clr) begin
         st   <= RX_IDLE;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            RX_IDLE: if (tick && !rxs) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (tick) begin
               if (cnt == CW'(HALF - 1)) begin
                  cnt <= '0;
                  if (!rxs) begin
                     st <= RX_DATA; idx <= '0; par <= 1'b0; perr_pend <= 1'b0;
                  end else begin
                     st <= RX_IDLE;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_WAITHI: if (rxs) st <= RX_IDLE;
            default: begin
               if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
               if (bit_end) begin
                  if (st == RX_DATA) begin
                     sh  <= {rxs, sh[BYTE_W-1:1]};
                     par <= par ^ rxs;
                     if (idx == last_bit(char8)) st <= par_en ? RX_PAR : RX_STOP;
                     else                        idx <= idx + 1'b1;
                  end else if (st == RX_PAR) begin
                     perr_pend <= ((par ^ rxs) != par_odd);
                     st        <= RX_STOP;
                  end else begin
                     done <= 1'b1;
                     data <= char8 ? sh : {1'b0, sh[BYTE_W-1:1]};
                     perr <= perr_pend;
                     ferr <= !rxs;
                     st   <= rxs ? RX_IDLE : RX_WAITHI;
                  end
               end
            end
         endcase
      end
   end

   AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5

endmodule

// File: rtl/sio_rxq.sv
module sio_rxq #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       ovf
);
   localparam int unsigned AW   = $clog2(DEPTH);
   localparam int unsigned CNTW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sio_rxq: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          pop_ok, push_ok;

   assign pop_ok  = pop && (count != '0) && !flush;
   assign push_ok = push && !flush && ((count != CNTW'(DEPTH)) || pop_ok);
   assign ovf     = push && !flush && !push_ok;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || flush)
      ovf |=> count == CNTW'(DEPTH)); // R7

   AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (pop && count != '0 && !push) |=> count == $past(count) - 1'b1); // R6

endmodule

// File: rtl/sio_uart_channel.sv
module sio_uart_channel
   import sio_uart_pkg::*;
#(
   parameter int unsigned BAUD_DIV  = 4,
   parameter int unsigned OSR       = 16,
   parameter int unsigned RXQ_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              ext_tick,
   input  logic              rxd,
   output logic              txd,
   output logic              irq_txe,
   output logic              irq_rxf,
   output logic              irq_rxerr
);
   localparam int unsigned QCW = $clog2(RXQ_DEPTH + 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("sio_uart_channel: OSR must be even and at least 4");
   end
   if (BAUD_DIV < 1) begin : g_bad_div
      $error("sio_uart_channel: BAUD_DIV must be at least 1");
   end

   mode_t             mode_q;
   ctrl_t             ctrl_q;
   logic [2:0]        ir_div_q;
   logic              ir_on_q;
   logic [BYTE_W-1:0] tx_buf;
   logic              tdbe, fer_q, per_q, oer_q;
   logic              int_tick, tick, load, tx_busy;
   logic              rx_done, rx_perr, rx_ferr;
   logic [BYTE_W-1:0] rx_data, q_dout;
   logic [QCW-1:0]    q_cnt;
   logic              q_ovf, q_pop, q_two;
   logic              wr_st, wr_tx, wr_mode, wr_ctrl, wr_exp;

   // ---------------- oversampling tick ----------------
   if (BAUD_DIV == 1) begin : g_div_bypass
      assign int_tick = 1'b1;
   end else begin : g_div
      localparam int unsigned DCW = $clog2(BAUD_DIV);
      logic [DCW-1:0] dcnt;
      always_ff @(posedge clk) begin
         if (!rst_n || !ctrl_q.en || dcnt == DCW'(BAUD_DIV - 1)) dcnt <= '0;
         else                                                     dcnt <= dcnt + 1'b1;
      end
      assign int_tick = ctrl_q.en && (dcnt == DCW'(BAUD_DIV - 1));
   end

   assign tick = mode_q.ext_clk ? ext_tick : int_tick;

   // ---------------- register writes ----------------
   assign wr_st   = reg_wr && (reg_addr == A_STAT);
   assign wr_tx   = reg_wr && (reg_addr == A_TXD);
   assign wr_mode = reg_wr && (reg_addr == A_MODE);
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_exp  = reg_wr && (reg_addr == A_EXP);
   assign q_pop   = reg_rd && (reg_addr == A_RXD);
   assign load    = ctrl_q.en && !tdbe && !tx_busy;
   assign q_two   = (q_cnt >= QCW'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= '0;
         ctrl_q   <= '0;
         ir_div_q <= '0;
         ir_on_q  <= 1'b0;
         tx_buf   <= '0;
         tdbe     <= 1'b1;
         fer_q    <= 1'b0;
         per_q    <= 1'b0;
         oer_q    <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= reg_wdata[4:0];
         if (wr_ctrl) ctrl_q <= {reg_wdata[6:4], reg_wdata[1:0]};
         if (wr_exp) begin
            ir_div_q <= reg_wdata[6:4];
            ir_on_q  <= reg_wdata[0];
         end
         if (wr_tx)     tx_buf <= reg_wdata;
         if (wr_tx)     tdbe   <= 1'b0;
         else if (load) tdbe   <= 1'b1;
         // hardware set wins over a same-cycle clear
         fer_q <= (fer_q & ~(wr_st & reg_wdata[6])) | (rx_done & rx_ferr);
         per_q <= (per_q & ~(wr_st & reg_wdata[5])) | (rx_done & rx_perr);
         oer_q <= (oer_q & ~(wr_st & reg_wdata[4])) | q_ovf;
      end
   end

   // ---------------- datapath ----------------
   sio_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.en), .tick(tick), .load(load),
      .din(tx_buf), .char8(mode_q.char8), .par_en(mode_q.par_en),
      .par_odd(mode_q.par_odd), .stop2(mode_q.stop2), .txd(txd), .busy(tx_busy)
   );

   sio_rx #(.OSR(OSR)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.en), .tick(tick), .rxd(rxd),
      .char8(mode_q.char8), .par_en(mode_q.par_en), .par_odd(mode_q.par_odd),
      .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
   );

   sio_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_q (
      .clk(clk), .rst_n(rst_n), .flush(!ctrl_q.en), .push(rx_done), .din(rx_data),
      .pop(q_pop), .dout(q_dout), .count(q_cnt), .ovf(q_ovf)
   );

   // ---------------- read mux ----------------
   always_comb begin
      case (reg_addr)
         A_STAT:  reg_rdata = {1'b0, fer_q, per_q, oer_q, q_two, tx_busy, (q_cnt != '0), tdbe};
         A_TXD:   reg_rdata = tx_buf;
         A_RXD:   reg_rdata = (q_cnt != '0) ? q_dout : '0;
         A_MODE:  reg_rdata = {3'b000, mode_q};
         A_CTRL:  reg_rdata = {1'b0, ctrl_q.err_ie, ctrl_q.rxf_ie, ctrl_q.txe_ie,
                               2'b00, ctrl_q.rx_two, ctrl_q.en};
         A_EXP:   reg_rdata = {1'b0, ir_div_q, 3'b000, ir_on_q};
         default: reg_rdata = '0;
      endcase
   end

   assign irq_txe   = ctrl_q.txe_ie & tdbe;
   assign irq_rxf   = ctrl_q.rxf_ie & (ctrl_q.rx_two ? q_two : (q_cnt != '0));
   assign irq_rxerr = ctrl_q.err_ie & (fer_q | per_q | oer_q);

   AST_LOAD_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !$past(tdbe)); // R3

   AST_OER_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oer_q) |-> $past(wr_st && reg_wdata[4])); // R9

   AST_PER_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(per_q) |-> $past(wr_st && reg_wdata[5])); // R9

   AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |=> q_cnt == '0); // R12

   AST_RXF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxf |-> q_cnt != '0); // R11

endmodule

// File: tb/sio_uart_channel_tb.sv
module sio_uart_channel_tb;
   import sio_uart_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       ext_tick = 1'b0, rxd = 1'b1, txd;
   logic       irq_txe, irq_rxf, irq_rxerr;

   int  vectors = 0, errs = 0;
   int  exp_q[$];
   bit  mon_en = 1'b1;
   int  cfg_nb = 8;
   bit  cfg_par = 0, cfg_odd = 0, cfg_stop2 = 0;

   always #5 clk = ~clk;

   sio_uart_channel #(.BAUD_DIV(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick), .rxd(rxd),
      .txd(txd), .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_rxerr(irq_rxerr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
      logic [7:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic send_tx(input logic [7:0] b);
      exp_q.push_back(cfg_nb == 8 ? b : {1'b0, b[6:0]});
      wr(A_TXD, b);
   endtask

   task automatic send_frame(input logic [7:0] b, input int nb, input bit pe, input bit podd,
                             input bit bad_par, input bit bad_stop);
      logic p;
      p = podd ^ bad_par;
      @(negedge clk); rxd = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = b[i]; p = p ^ b[i];
         repeat (16) @(negedge clk);
      end
      if (pe) begin
         rxd = p;
         repeat (16) @(negedge clk);
      end
      rxd = !bad_stop;
      repeat (16) @(negedge clk);
      rxd = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic samp();
      @(negedge clk); #1;
   endtask

   // transmit monitor: decodes frames on txd and scores them against exp_q
   initial begin : mon
      logic       prev;
      logic [7:0] got;
      logic       pexp;
      int         want;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (mon_en && rst_n && prev && !txd) begin
            repeat (8) @(negedge clk);
            chk("R2 start bit low at mid-bit", txd, 0);
            got = '0;
            for (int i = 0; i < cfg_nb; i++) begin
               repeat (16) @(negedge clk);
               got[i] = txd;
            end
            if (cfg_par) begin
               repeat (16) @(negedge clk);
               pexp = (^got) ^ cfg_odd;
               chk("R4 parity bit", txd, pexp);
            end
            repeat (16) @(negedge clk);
            chk("R2 stop bit high", txd, 1);
            if (cfg_stop2) begin
               repeat (16) @(negedge clk);
               chk("R4 second stop bit high", txd, 1);
            end
            if (exp_q.size() == 0) begin
               chk("R2 unexpected frame", got, 'h100);
            end else begin
               want = exp_q.pop_front();
               chk("R2 tx data", got, want);
            end
         end
         prev = txd;
      end
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin : main
      logic [7:0] d, st;
      bit saw_oer, saw_keep;
      saw_oer = 0; saw_keep = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_chk(A_STAT, 'h01, "R1 status");
      rd_chk(A_TXD,  'h00, "R1 tx data");
      rd_chk(A_RXD,  'h00, "R1 rx data");
      rd_chk(A_MODE, 'h00, "R1 mode");
      rd_chk(A_CTRL, 'h00, "R1 control");
      rd_chk(A_EXP,  'h00, "R1 expansion");
      samp();
      chk("R1 irq outputs", {irq_txe, irq_rxf, irq_rxerr}, 0);

      wr(A_CTRL, 'h01);
      wr(A_MODE, 'h10);
      cfg_nb = 8; cfg_par = 0; cfg_stop2 = 0;

      // R2 / R3 transmit and holding flags
      send_tx('hA5);
      send_tx('h3C);
      rd_chk(A_STAT, 'h04, "R3 busy with holding full");
      repeat (360) @(negedge clk);
      rd_chk(A_STAT, 'h01, "R3 idle and empty after frames");

      // R4 7-bit odd parity two stops, back to back
      wr(A_MODE, 'h0E);
      cfg_nb = 7; cfg_par = 1; cfg_odd = 1; cfg_stop2 = 1;
      send_tx('hD5);
      send_tx('h2B);
      repeat (460) @(negedge clk);
      // R4 8-bit even parity one stop
      wr(A_MODE, 'h18);
      cfg_nb = 8; cfg_par = 1; cfg_odd = 0; cfg_stop2 = 0;
      send_tx('h81);
      repeat (220) @(negedge clk);

      // R5 receive
      wr(A_MODE, 'h10);
      cfg_par = 0;
      send_frame('h5A, 8, 0, 0, 0, 0);
      rd_chk(A_STAT, 'h03, "R5 data ready");
      rd_chk(A_RXD, 'h5A, "R5 rx byte");
      rd_chk(A_STAT, 'h01, "R5 empty after read");
      wr(A_MODE, 'h00);
      send_frame('hD5, 7, 0, 0, 0, 0);
      rd_chk(A_RXD, 'h55, "R5 7-bit bit7 zero");

      // R6 two entries oldest first
      wr(A_MODE, 'h10);
      send_frame('h11, 8, 0, 0, 0, 0);
      send_frame('h22, 8, 0, 0, 0, 0);
      rd_chk(A_STAT, 'h0B, "R6 second byte flag");
      rd_chk(A_RXD, 'h11, "R6 oldest first");
      rd_chk(A_RXD, 'h22, "R6 second entry");
      rd_chk(A_RXD, 'h00, "R6 empty read");

      // R11 interrupts
      wr(A_CTRL, 'h31);
      samp();
      chk("R11 irq_txe", irq_txe, 1);
      chk("R11 irq_rxf empty", irq_rxf, 0);
      send_frame('h44, 8, 0, 0, 0, 0);
      samp();
      chk("R11 irq_rxf one entry", irq_rxf, 1);
      wr(A_CTRL, 'h33);
      samp();
      chk("R11 irq_rxf threshold two", irq_rxf, 0);
      send_frame('h45, 8, 0, 0, 0, 0);
      samp();
      chk("R11 irq_rxf two entries", irq_rxf, 1);
      rd(A_RXD, d); rd(A_RXD, d);
      wr(A_CTRL, 'h01);

      // R7 simple overrun
      send_frame('h01, 8, 0, 0, 0, 0);
      send_frame('h02, 8, 0, 0, 0, 0);
      send_frame('h03, 8, 0, 0, 0, 0);
      rd_chk(A_STAT, 'h1B, "R7 overrun flag");
      rd_chk(A_RXD, 'h01, "R7 kept first");
      rd_chk(A_RXD, 'h02, "R7 kept second");
      rd_chk(A_RXD, 'h00, "R7 third discarded");

      // R9 write-one-to-clear
      wr(A_STAT, 'h00);
      rd_chk(A_STAT, 'h11, "R9 write 0 keeps flag");
      wr(A_STAT, 'h0F);
      rd_chk(A_STAT, 'h11, "R9 low bits not writable");
      wr(A_STAT, 'h10);
      rd_chk(A_STAT, 'h01, "R9 write 1 clears");

      // R8 parity error
      wr(A_MODE, 'h18);
      send_frame('h33, 8, 1, 0, 1, 0);
      rd_chk(A_STAT, 'h23, "R8 parity error flag");
      rd_chk(A_RXD, 'h33, "R8 data kept on parity error");
      wr(A_CTRL, 'h41);
      samp();
      chk("R11 irq_rxerr", irq_rxerr, 1);
      wr(A_STAT, 'h20);
      samp();
      chk("R11 irq_rxerr cleared", irq_rxerr, 0);
      // R8 framing error
      wr(A_MODE, 'h10);
      send_frame('h77, 8, 0, 0, 0, 1);
      rd_chk(A_STAT, 'h43, "R8 framing error flag");
      rd_chk(A_RXD, 'h77, "R8 data kept on framing error");
      wr(A_STAT, 'h40);
      wr(A_CTRL, 'h01);
      rd_chk(A_STAT, 'h01, "R9 framing cleared");

      // R10 register fields
      wr(A_MODE, 'hFF);
      rd_chk(A_MODE, 'h1F, "R10 mode mask");
      wr(A_CTRL, 'hFF);
      rd_chk(A_CTRL, 'h73, "R10 control mask");
      wr(A_EXP, 'hFF);
      rd_chk(A_EXP, 'h71, "R10 expansion mask");
      wr(A_EXP, 'h35);
      rd_chk(A_EXP, 'h31, "R10 expansion code");
      wr(A_MODE, 'h10);
      wr(A_CTRL, 'h01);

      // R12 disable
      send_frame('h66, 8, 0, 0, 0, 0);
      rd_chk(A_STAT, 'h03, "R12 entry before disable");
      wr(A_CTRL, 'h00);
      rd_chk(A_STAT, 'h01, "R12 flushed");
      wr(A_CTRL, 'h01);
      rd_chk(A_RXD, 'h00, "R12 queue empty");
      rd_chk(A_MODE, 'h10, "R12 mode kept");

      // R13 external tick
      mon_en = 1'b0;
      wr(A_MODE, 'h11);
      ext_tick = 1'b0;
      wr(A_TXD, 'h99);
      repeat (200) @(negedge clk);
      rd_chk(A_STAT, 'h05, "R13 stalled without ext tick");
      chk("R13 line held in start bit", txd, 0);
      ext_tick = 1'b1;
      repeat (200) @(negedge clk);
      rd_chk(A_STAT, 'h01, "R13 completes with ext tick");
      mon_en = 1'b1;
      send_tx('h4E);
      repeat (200) @(negedge clk);
      wr(A_MODE, 'h10);
      ext_tick = 1'b0;

      // R7 read swept across completion of a third character
      for (int k = 0; k < 32; k++) begin
         send_frame(8'h10 + 8'(k), 8, 0, 0, 0, 0);
         send_frame(8'h40 + 8'(k), 8, 0, 0, 0, 0);
         fork
            send_frame(8'h80 + 8'(k), 8, 0, 0, 0, 0);
            begin
               repeat (140 + k) @(negedge clk);
               reg_addr = A_RXD; reg_rd = 1'b1; #1 d = reg_rdata;
               @(negedge clk); reg_rd = 1'b0;
            end
         join
         chk("R7 sweep oldest first", d, 8'h10 + 8'(k));
         rd(A_STAT, st);
         rd_chk(A_RXD, 8'h40 + 8'(k), "R7 sweep second kept");
         if (st[4]) begin
            saw_oer = 1;
            rd_chk(A_RXD, 'h00, "R7 overrun means third dropped");
            wr(A_STAT, 'h10);
         end else begin
            saw_keep = 1;
            rd_chk(A_RXD, 8'h80 + 8'(k), "R7 no overrun means third stored");
         end
      end
      chk("R7 sweep hit both outcomes", {saw_oer, saw_keep}, 2'b11);

      chk("R2 all tx frames seen", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule